// File: doc/BRIEF.md
# Multiplicative Boost Frequency Controller

This block is the decision engine behind an activity-driven clock governor. A monitoring channel elsewhere flags that its averaged activity has stayed above or below its watermarks for several sampling periods in a row. On each such evaluation the controller updates a boost frequency. Sustained high activity grows the boost geometrically by a percentage coefficient plus a fixed step, up to the maximum frequency. Sustained low activity shrinks it by a second coefficient, and a boost that becomes small is dropped to zero. The controller also decides whether each of the two consecutive-event detectors stays armed.

Each evaluation also produces a target frequency and a fresh set of watermarks for the monitoring channel. The target is the average count converted to a per-period rate, scaled by a sustain factor derived from the upper threshold, plus the boost. The watermarks are a pair of raw activity limits derived from the current clock rate, and a band around the measured average.

An evaluation is a short sequential walk through the stages multiply, divide, clamp and write-back. The result is announced with a one-cycle `done` pulse.

Top module: `boost_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `boost_freq`, `target_freq` and all four watermark outputs are 0, `arm_above` and `arm_below` are 1, and `busy` and `done` are 0.
- R2: For an above evaluation (`evt_above`=1), the new boost is min(2^32-1, boost × up_coeff / 100) + 16000, saturating at 2^32-1. `arm_below` becomes 1.
- R3: If the boost from R2 is at or above `cfg_max_freq`, it is replaced by `cfg_max_freq` and `arm_above` becomes 0. Otherwise `arm_above` becomes 1.
- R4: For a below evaluation (`evt_below`=1, `evt_above`=0), the new boost is boost × down_coeff / 100, saturating at 2^32-1. `arm_above` becomes 1.
- R5: If the boost from R4 is less than 8000, it becomes 0 and `arm_below` becomes 0. Otherwise `arm_below` becomes 1.
- R6: When `evt_above` and `evt_below` are both 1, the evaluation follows R2/R3 only.
- R7: When `cfg_dep_level` is nonzero, an average at or above it sets `arm_below` to 1 after R2–R5 are applied. An average below it, together with a resulting boost of 0, sets `arm_below` to 0.
- R8: The target is ((avg / 12) × (10000 / up_pct)) / 100, saturated, plus the new boost, saturated. All divisions truncate, and an up_pct of 0 is treated as a factor of 10000.
- R9: The raw upper watermark is (cur × 12) × up_pct / 100. The raw lower watermark is (cur × 12) × down_pct / 100. Both saturate at 2^32-1.
- R10: With band = (max × 6 / 1000) × 12, the average upper watermark is avg + band (saturating). The average lower watermark is avg − band, or 0 when avg ≤ band.
- R11: `evt_valid` is taken only while `busy` is 0. Outputs change together with a one-cycle `done` pulse on the fourth rising edge after the accepting edge. Requests made while `busy` is 1 are ignored.
- R12: The six `cfg_*` inputs are captured while `rst` is high. Changes made after reset has been released have no effect.
- R13: An evaluation with neither event flag set keeps the boost and the arm bits unchanged (R7 still applies) and refreshes the target and the watermarks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; configuration is captured while high |
| cfg_up_coeff | input | 16 | Growth coefficient in percent |
| cfg_down_coeff | input | 16 | Decay coefficient in percent |
| cfg_up_pct | input | 8 | Upper activity threshold in percent |
| cfg_down_pct | input | 8 | Lower activity threshold in percent |
| cfg_dep_level | input | 32 | Average-dependency level; 0 disables the override |
| cfg_max_freq | input | 32 | Maximum frequency, the boost ceiling |
| evt_valid | input | 1 | Request an evaluation |
| evt_above | input | 1 | Consecutive-above event present |
| evt_below | input | 1 | Consecutive-below event present |
| avg_count | input | 32 | Measured average activity count |
| cur_freq | input | 32 | Current clock frequency |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse: results updated |
| boost_freq | output | 32 | Current boost value |
| target_freq | output | 32 | Computed target frequency |
| arm_above | output | 1 | Enable for consecutive-above detection |
| arm_below | output | 1 | Enable for consecutive-below detection |
| wm_upper | output | 32 | Raw upper watermark |
| wm_lower | output | 32 | Raw lower watermark |
| wm_avg_upper | output | 32 | Average upper watermark |
| wm_avg_lower | output | 32 | Average lower watermark |

## Verification
The boost is the only value carried from one evaluation to the next. A wrong multiply, clamp or snap therefore appears in `boost_freq` and `target_freq` at the very next `done`. The error then compounds through every later evaluation, so long chains of above and below events are swept until the boost reaches both the ceiling and zero.

A wrong arm decision is visible at the same `done`. Wrong handshake timing shows up as `done` arriving on the wrong cycle, or as a request made while busy changing the result.

// File: rtl/boost_pkg.sv
package boost_pkg;

    localparam int BW = 32;
    localparam int CW = 16;
    localparam int PW = 8;

    typedef logic [BW-1:0]   word_t;
    typedef logic [2*BW-1:0] dword_t;

    localparam word_t WORD_MAX = '1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_DIV,
        ST_CLAMP,
        ST_WB
    } bst_state_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_UP,
        EV_DOWN
    } bst_event_e;

    typedef struct packed {
        word_t         max_freq;
        word_t         dep_level;
        logic [CW-1:0] up_coeff;
        logic [CW-1:0] down_coeff;
        logic [PW-1:0] up_pct;
        logic [PW-1:0] down_pct;
    } bst_cfg_t;

    function automatic word_t sat_word(dword_t x);
        return (x > dword_t'(WORD_MAX)) ? WORD_MAX : x[BW-1:0];
    endfunction

    function automatic word_t add_sat(word_t a, word_t b);
        return sat_word(dword_t'(a) + dword_t'(b));
    endfunction

    function automatic word_t pct_of(word_t v, dword_t pct);
        return sat_word((dword_t'(v) * pct) / dword_t'(100));
    endfunction

endpackage

// File: rtl/boost_target_calc.sv
module boost_target_calc
    import boost_pkg::*;
#(
    parameter int PERIOD = 12
) (
    input  word_t         avg,
    input  word_t         boost,
    input  logic [PW-1:0] up_pct,
    output word_t         target
);
    localparam word_t PERIOD_W  = word_t'(PERIOD);
    localparam word_t SUSTAIN_K = word_t'(10000);

    word_t per_period;
    word_t sustain;
    word_t scaled;

    always_comb begin
        per_period = avg / PERIOD_W;
        sustain    = (up_pct == '0) ? SUSTAIN_K : SUSTAIN_K / word_t'(up_pct);
        scaled     = pct_of(per_period, dword_t'(sustain));
        target     = add_sat(scaled, boost);
    end
endmodule

// File: rtl/boost_wmark_calc.sv
module boost_wmark_calc
    import boost_pkg::*;
#(
    parameter int PERIOD        = 12,
    parameter int BAND_PERMILLE = 6
) (
    input  word_t         cur,
    input  word_t         avg,
    input  word_t         max_freq,
    input  logic [PW-1:0] up_pct,
    input  logic [PW-1:0] down_pct,
    output word_t         upper,
    output word_t         lower,
    output word_t         avg_upper,
    output word_t         avg_lower
);
    word_t base;
    word_t band_rate;
    word_t band;

    always_comb begin
        base      = sat_word(dword_t'(cur) * dword_t'(PERIOD));
        upper     = pct_of(base, dword_t'(up_pct));
        lower     = pct_of(base, dword_t'(down_pct));
        band_rate = sat_word((dword_t'(max_freq) * dword_t'(BAND_PERMILLE)) / dword_t'(1000));
        band      = sat_word(dword_t'(band_rate) * dword_t'(PERIOD));
        avg_upper = add_sat(avg, band);
        avg_lower = (avg > band) ? (avg - band) : '0;
    end
endmodule

// File: rtl/boost_ctrl.sv
module boost_ctrl
    import boost_pkg::*;
#(
    parameter int PERIOD        = 12,
    parameter int BOOST_STEP    = 16000,
    parameter int BAND_PERMILLE = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cfg_up_coeff,
    input  logic [CW-1:0] cfg_down_coeff,
    input  logic [PW-1:0] cfg_up_pct,
    input  logic [PW-1:0] cfg_down_pct,
    input  logic [BW-1:0] cfg_dep_level,
    input  logic [BW-1:0] cfg_max_freq,
    input  logic          evt_valid,
    input  logic          evt_above,
    input  logic          evt_below,
    input  logic [BW-1:0] avg_count,
    input  logic [BW-1:0] cur_freq,
    output logic          busy,
    output logic          done,
    output logic [BW-1:0] boost_freq,
    output logic [BW-1:0] target_freq,
    output logic          arm_above,
    output logic          arm_below,
    output logic [BW-1:0] wm_upper,
    output logic [BW-1:0] wm_lower,
    output logic [BW-1:0] wm_avg_upper,
    output logic [BW-1:0] wm_avg_lower
);
    localparam word_t STEP_W = word_t'(BOOST_STEP);
    localparam word_t HALF_W = word_t'(BOOST_STEP / 2);

    bst_cfg_t   cfg_q;
    bst_state_e st_q;
    bst_event_e ev_q;
    word_t      avg_l, cur_l;
    dword_t     prod_q;
    word_t      nb_q, boost_q;
    logic       aa_q, ab_q, aa_n_q, ab_n_q, done_q;
    word_t      target_q, wmu_q, wml_q, wmau_q, wmal_q;

    word_t div_q;
    word_t c_boost;
    logic  c_aa, c_ab;
    word_t tgt_c, wmu_c, wml_c, wmau_c, wmal_c;

    assign div_q = sat_word(prod_q / dword_t'(100));

    // clamp stage: ceiling, snap to zero, re-arm choice, dependency override
    always_comb begin
        c_boost = nb_q;
        c_aa    = aa_q;
        c_ab    = ab_q;
        unique case (ev_q)
            EV_UP: begin
                c_ab = 1'b1;
                if (nb_q >= cfg_q.max_freq) begin
                    c_boost = cfg_q.max_freq;
                    c_aa    = 1'b0;
                end else begin
                    c_aa = 1'b1;
                end
            end
            EV_DOWN: begin
                c_aa = 1'b1;
                if (nb_q < HALF_W) begin
                    c_boost = '0;
                    c_ab    = 1'b0;
                end else begin
                    c_ab = 1'b1;
                end
            end
            default: ;
        endcase
        if (cfg_q.dep_level != '0) begin
            if (avg_l >= cfg_q.dep_level)
                c_ab = 1'b1;
            else if (c_boost == '0)
                c_ab = 1'b0;
        end
    end

    boost_target_calc #(.PERIOD(PERIOD)) u_target (
        .avg    (avg_l),
        .boost  (nb_q),
        .up_pct (cfg_q.up_pct),
        .target (tgt_c)
    );

    boost_wmark_calc #(.PERIOD(PERIOD), .BAND_PERMILLE(BAND_PERMILLE)) u_wmark (
        .cur       (cur_l),
        .avg       (avg_l),
        .max_freq  (cfg_q.max_freq),
        .up_pct    (cfg_q.up_pct),
        .down_pct  (cfg_q.down_pct),
        .upper     (wmu_c),
        .lower     (wml_c),
        .avg_upper (wmau_c),
        .avg_lower (wmal_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '{max_freq: cfg_max_freq, dep_level: cfg_dep_level,
                          up_coeff: cfg_up_coeff, down_coeff: cfg_down_coeff,
                          up_pct: cfg_up_pct, down_pct: cfg_down_pct};
            st_q     <= ST_IDLE;
            ev_q     <= EV_NONE;
            avg_l    <= '0;
            cur_l    <= '0;
            prod_q   <= '0;
            nb_q     <= '0;
            boost_q  <= '0;
            aa_q     <= 1'b1;
            ab_q     <= 1'b1;
            aa_n_q   <= 1'b1;
            ab_n_q   <= 1'b1;
            done_q   <= 1'b0;
            target_q <= '0;
            wmu_q    <= '0;
            wml_q    <= '0;
            wmau_q   <= '0;
            wmal_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (evt_valid) begin
                    ev_q  <= evt_above ? EV_UP : (evt_below ? EV_DOWN : EV_NONE);
                    avg_l <= avg_count;
                    cur_l <= cur_freq;
                    st_q  <= ST_MUL;
                end
                ST_MUL: begin
                    prod_q <= dword_t'(boost_q) *
                              dword_t'((ev_q == EV_UP) ? cfg_q.up_coeff : cfg_q.down_coeff);
                    st_q   <= ST_DIV;
                end
                ST_DIV: begin
                    nb_q <= (ev_q == EV_UP)   ? add_sat(div_q, STEP_W) :
                            (ev_q == EV_DOWN) ? div_q : boost_q;
                    st_q <= ST_CLAMP;
                end
                ST_CLAMP: begin
                    nb_q   <= c_boost;
                    aa_n_q <= c_aa;
                    ab_n_q <= c_ab;
                    st_q   <= ST_WB;
                end
                ST_WB: begin
                    boost_q  <= nb_q;
                    aa_q     <= aa_n_q;
                    ab_q     <= ab_n_q;
                    target_q <= tgt_c;
                    wmu_q    <= wmu_c;
                    wml_q    <= wml_c;
                    wmau_q   <= wmau_c;
                    wmal_q   <= wmal_c;
                    done_q   <= 1'b1;
                    st_q     <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (st_q != ST_IDLE);
    assign done         = done_q;
    assign boost_freq   = boost_q;
    assign target_freq  = target_q;
    assign arm_above    = aa_q;
    assign arm_below    = ab_q;
    assign wm_upper     = wmu_q;
    assign wm_lower     = wml_q;
    assign wm_avg_upper = wmau_q;
    assign wm_avg_lower = wmal_q;

    assert_boost_ceiling_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> boost_freq <= cfg_q.max_freq);

    assert_no_small_boost_R5: assert property (@(posedge clk) disable iff (rst)
        (done && cfg_q.max_freq >= HALF_W) |-> (boost_freq == '0 || boost_freq >= HALF_W));

    assert_up_rearms_below_R2: assert property (@(posedge clk) disable iff (rst)
        (done && ev_q == EV_UP && boost_freq != '0) |-> arm_below);

    assert_down_rearms_above_R4: assert property (@(posedge clk) disable iff (rst)
        (done && ev_q == EV_DOWN) |-> arm_above);

    assert_boost_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_WB) |=> $stable(boost_freq));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_target_floor_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> target_freq >= boost_freq);

endmodule

// File: tb/boost_ctrl_tb.sv
module boost_ctrl_tb_top;
    import boost_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst;
    logic [CW-1:0] cfg_up_coeff, cfg_down_coeff;
    logic [PW-1:0] cfg_up_pct, cfg_down_pct;
    logic [BW-1:0] cfg_dep_level, cfg_max_freq;
    logic          evt_valid, evt_above, evt_below;
    logic [BW-1:0] avg_count, cur_freq;
    logic          busy, done, arm_above, arm_below;
    logic [BW-1:0] boost_freq, target_freq, wm_upper, wm_lower, wm_avg_upper, wm_avg_lower;

    boost_ctrl dut_i (
        .clk(clk), .rst(rst),
        .cfg_up_coeff(cfg_up_coeff), .cfg_down_coeff(cfg_down_coeff),
        .cfg_up_pct(cfg_up_pct), .cfg_down_pct(cfg_down_pct),
        .cfg_dep_level(cfg_dep_level), .cfg_max_freq(cfg_max_freq),
        .evt_valid(evt_valid), .evt_above(evt_above), .evt_below(evt_below),
        .avg_count(avg_count), .cur_freq(cur_freq),
        .busy(busy), .done(done), .boost_freq(boost_freq), .target_freq(target_freq),
        .arm_above(arm_above), .arm_below(arm_below),
        .wm_upper(wm_upper), .wm_lower(wm_lower),
        .wm_avg_upper(wm_avg_upper), .wm_avg_lower(wm_avg_lower)
    );

    localparam longint LMAX = 64'd4294967295;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // model configuration and state
    longint m_cu, m_cd, m_up, m_dp, m_dep, m_max;
    longint m_b;
    bit     m_aa, m_ab;

    function automatic longint sat(longint x);
        return (x > LMAX) ? LMAX : x;
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(longint cu, longint cd, longint up, longint dp, longint dep, longint mx);
        @(negedge clk);
        rst = 1'b1;
        cfg_up_coeff = CW'(cu); cfg_down_coeff = CW'(cd);
        cfg_up_pct = PW'(up); cfg_down_pct = PW'(dp);
        cfg_dep_level = BW'(dep); cfg_max_freq = BW'(mx);
        m_cu = cu; m_cd = cd; m_up = up; m_dp = dp; m_dep = dep; m_max = mx;
        m_b = 0; m_aa = 1; m_ab = 1;
        repeat (2) @(negedge clk);
        chk("R1", "boost in reset", longint'(boost_freq), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "boost", longint'(boost_freq), 0);
        chk("R1", "target", longint'(target_freq), 0);
        chk("R1", "arm_above", longint'(arm_above), 1);
        chk("R1", "arm_below", longint'(arm_below), 1);
        chk("R1", "busy/done", longint'({busy, done}), 0);
        chk("R1", "watermarks", longint'(wm_upper | wm_lower | wm_avg_upper | wm_avg_lower), 0);
    endtask

    // runs one evaluation; caller is at a falling edge
    task automatic run_eval(string req, bit up, bit dn, longint avg, longint cur, bit poke);
        longint b, t, base, band, br;
        bit aa, ab;
        evt_valid = 1'b1; evt_above = up; evt_below = dn;
        avg_count = BW'(avg); cur_freq = BW'(cur);
        @(negedge clk);
        evt_valid = 1'b0;
        chk("R11", "busy after accept", longint'(busy), 1);
        if (poke) begin
            evt_valid = 1'b1; evt_above = !up; evt_below = !dn;
            avg_count = BW'(avg + 12345); cur_freq = BW'(cur + 777);
        end
        @(negedge clk);
        evt_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11", "done early", longint'(done), 0);
        @(negedge clk);
        chk("R11", "done pulse", longint'(done), 1);

        b = m_b; aa = m_aa; ab = m_ab;
        if (up) begin
            b = sat(sat(b * m_cu / 100) + 16000);
            ab = 1;
            if (b >= m_max) begin b = m_max; aa = 0; end else aa = 1;
        end else if (dn) begin
            b = sat(b * m_cd / 100);
            aa = 1;
            if (b < 8000) begin b = 0; ab = 0; end else ab = 1;
        end
        if (m_dep != 0) begin
            if (avg >= m_dep) ab = 1;
            else if (b == 0) ab = 0;
        end
        m_b = b; m_aa = aa; m_ab = ab;
        t = sat(sat((avg / 12) * ((m_up == 0) ? 10000 : 10000 / m_up) / 100) + b);

        chk(req, "boost", longint'(boost_freq), b);
        chk(req, "arm_above", longint'(arm_above), longint'(aa));
        chk(req, "arm_below", longint'(arm_below), longint'(ab));
        chk("R8", "target", longint'(target_freq), t);
        base = sat(cur * 12);
        chk("R9", "wm_upper", longint'(wm_upper), sat(base * m_up / 100));
        chk("R9", "wm_lower", longint'(wm_lower), sat(base * m_dp / 100));
        br = m_max * 6 / 1000;
        band = sat(br * 12);
        chk("R10", "wm_avg_upper", longint'(wm_avg_upper), sat(avg + band));
        chk("R10", "wm_avg_lower", longint'(wm_avg_lower), (avg > band) ? avg - band : 0);
        @(negedge clk);
        chk("R11", "done one cycle", longint'(done), 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R11: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; evt_valid = 1'b0; evt_above = 1'b0; evt_below = 1'b0;
        avg_count = '0; cur_freq = '0;

        // profile with moderate coefficients, no dependency override
        do_reset(200, 50, 60, 40, 0, 800000);
        for (int i = 0; i < 7; i++)
            run_eval("R2 R3", 1'b1, 1'b0, 100000 + i * 41234, 400000 + i * 1000, i == 2);
        for (int i = 0; i < 10; i++)
            run_eval("R4 R5", 1'b0, 1'b1, (i * 37123 + 1000) % 200000, 300000, i == 4);
        run_eval("R13", 1'b0, 1'b0, 5000, 204000, 1'b0);
        run_eval("R2", 1'b1, 1'b0, 70000, 204000, 1'b0);
        run_eval("R6", 1'b1, 1'b1, 90000, 204000, 1'b0);
        run_eval("R13", 1'b0, 1'b0, 90000, 204000, 1'b0);
        run_eval("R5", 1'b0, 1'b1, 90000, 204000, 1'b0);

        // configuration changed after reset must be ignored
        cfg_up_coeff = 16'd800; cfg_up_pct = 8'd10; cfg_max_freq = 32'd100;
        run_eval("R12", 1'b1, 1'b0, 60000, 204000, 1'b0);
        run_eval("R12", 1'b1, 1'b0, 60000, 204000, 1'b0);

        // aggressive profile with average-dependency override
        do_reset(800, 90, 27, 10, 50000, 933000);
        for (int i = 0; i < 5; i++)
            run_eval("R2 R3 R7", 1'b1, 1'b0, (i % 2 == 0) ? 60000 : 20000, 533000, i == 1);
        for (int i = 0; i < 40; i++)
            run_eval("R4 R5 R7", 1'b0, 1'b1, (i % 3 == 0) ? 50000 : 49999, 533000, 1'b0);
        run_eval("R7", 1'b0, 1'b0, 49999, 533000, 1'b0);
        run_eval("R7", 1'b0, 1'b0, 50000, 533000, 1'b0);
        run_eval("R6", 1'b1, 1'b1, 10, 533000, 1'b0);

        // saturation corners: huge maximum and coefficients
        do_reset(65535, 65535, 1, 0, 0, 64'd4294967295);
        for (int i = 0; i < 5; i++)
            run_eval("R2 R3", 1'b1, 1'b0, 64'd4294967295, 64'd4294967295, 1'b0);
        run_eval("R4", 1'b0, 1'b1, 0, 0, 1'b0);

        // zero up_pct and a small ceiling
        do_reset(150, 20, 0, 5, 0, 20000);
        for (int i = 0; i < 4; i++)
            run_eval("R3 R8", 1'b1, 1'b0, 120000 * i, 1000, 1'b0);
        for (int i = 0; i < 3; i++)
            run_eval("R5", 1'b0, 1'b1, 7, 1000, 1'b0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule